// File: doc/BRIEF.md
# Three-Way Whole-Word Voter

This block takes three redundant copies of a data word and produces one word from them. Each copy comes from a replicated module. It never votes bit by bit. A per-bit majority can produce a word that matches none of the copies, so the block always returns one of the three input words unchanged.

Two selection rules are available, chosen by a mode input that is sampled together with the data.
- **Compare-select mode:** copy A is compared with copy B. When they match, A is forwarded. When they differ, C is forwarded.
- **Median mode:** the three words are treated as unsigned numbers and the middle one is forwarded.

In both modes, two flags travel with the result. One reports that A and B disagree. The other reports that no two copies are equal. The selection logic is combinational. It feeds a single output register stage, and that stage carries a valid strobe.

Top module: `word_vote3`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `out_word`, `out_disagree` and `out_alldiff` are all 0.
- R2: When `mode_med` = 0 and `word_a` equals `word_b`, the registered result is `word_a`.
- R3: When `mode_med` = 0 and `word_a` differs from `word_b`, the registered result is `word_c`.
- R4: `out_disagree` is 1 exactly when the sampled `word_a` differs from the sampled `word_b`. This holds in both modes.
- R5: When `mode_med` = 1, the result is the unsigned middle value of the three words. When two or three words are equal, the result is that tied value.
- R6: `out_alldiff` is 1 exactly when all three sampled words are pairwise different.
- R7: `out_valid` is high on the cycle after each cycle in which `in_valid` is high, and low otherwise. Result and flags update on that same edge.
- R8: A cycle with `in_valid` low leaves `out_word`, `out_disagree` and `out_alldiff` unchanged, whatever the data and mode inputs carry.
- R9: Every valid result equals at least one of the three sampled input words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data and mode inputs are sampled this cycle |
| mode_med | input | 1 | 0 = compare-select, 1 = unsigned median |
| word_a | input | W | First copy |
| word_b | input | W | Second copy |
| word_c | input | W | Third copy |
| out_valid | output | 1 | Result registered from the previous cycle's valid input |
| out_word | output | W | Selected word |
| out_disagree | output | 1 | A and B differed |
| out_alldiff | output | 1 | No two copies were equal |

## Verification
Faults in the equality detectors show at the ports in different ways.
- **Equality detectors:** a wrong detector output corrupts `out_disagree` or `out_alldiff`. In compare-select mode it also forwards the wrong copy. All of these appear on the edge after the valid input.
- **Median network:** a wrong ordering comparison only shows when the three words are distinct and the swapped pair decides the middle value. The bench therefore mixes strictly ordered triples in every permutation with the tie cases.
- **Capture enable:** a stuck or inverted enable leaves stale data or updates during idle cycles. This shows on the first idle or valid cycle that follows.

// File: rtl/vote_pkg.sv
package vote_pkg;
  typedef enum logic {
    VM_CMPSEL = 1'b0,
    VM_MEDIAN = 1'b1
  } vote_mode_e;

  typedef struct packed {
    logic eq_ab;
    logic eq_bc;
    logic eq_ac;
  } vote_eq_t;
endpackage

// File: rtl/vote_eq3.sv
module vote_eq3 #(
  parameter int W = 8
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [W-1:0]      c,
  output vote_pkg::vote_eq_t eq,
  output logic              disagree,
  output logic              alldiff
);
  always_comb begin
    eq.eq_ab = (a == b);
    eq.eq_bc = (b == c);
    eq.eq_ac = (a == c);
    disagree = ~eq.eq_ab;
    alldiff  = ~(eq.eq_ab | eq.eq_bc | eq.eq_ac);
  end
endmodule

// File: rtl/vote_cmpsel.sv
module vote_cmpsel #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] c,
  input  logic         ab_match,
  output logic [W-1:0] y
);
  always_comb y = ab_match ? a : c;
endmodule

// File: rtl/vote_median3.sv
module vote_median3 #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  logic [W-1:0] lo_ab, hi_ab, lo_hc;
  always_comb begin
    lo_ab = (a < b) ? a : b;
    hi_ab = (a < b) ? b : a;
    lo_hc = (hi_ab < c) ? hi_ab : c;
    y     = (lo_ab < lo_hc) ? lo_hc : lo_ab;
  end
endmodule

// File: rtl/word_vote3.sv
module word_vote3 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         mode_med,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_c,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic         out_disagree,
  output logic         out_alldiff
);
  import vote_pkg::*;

  vote_eq_t     eq;
  logic         dis_c, alld_c;
  logic [W-1:0] sel_cs, sel_md, sel_c;
  vote_mode_e   mode;

  assign mode = vote_mode_e'(mode_med);

  vote_eq3 #(.W(W)) u_eq (
    .a(word_a), .b(word_b), .c(word_c),
    .eq(eq), .disagree(dis_c), .alldiff(alld_c)
  );

  vote_cmpsel #(.W(W)) u_cs (
    .a(word_a), .c(word_c), .ab_match(eq.eq_ab), .y(sel_cs)
  );

  vote_median3 #(.W(W)) u_md (
    .a(word_a), .b(word_b), .c(word_c), .y(sel_md)
  );

  always_comb sel_c = (mode == VM_MEDIAN) ? sel_md : sel_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_disagree <= 1'b0;
      out_alldiff  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word     <= sel_c;
        out_disagree <= dis_c;
        out_alldiff  <= alld_c;
      end
    end
  end

  // R7: valid strobe follows the input strobe by one edge
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4: disagree flag tracks the A/B comparison
  a_r4_disagree: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_disagree == ($past(word_a) != $past(word_b))));
  // R9: result is always one whole input word
  a_r9_whole_word: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word == $past(word_a) || out_word == $past(word_b)
                  || out_word == $past(word_c)));
  // R8: idle cycles leave the result alone
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_disagree) && $stable(out_alldiff)));
  // R6: all-differ excludes any equal pair
  a_r6_alldiff: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (word_a == word_c || word_b == word_c)) |=> !out_alldiff);
endmodule

// File: tb/sim_word_vote3.sv
`timescale 1ns/1ps
module sim_word_vote3;
  localparam int W = 8;

  typedef struct {
    logic [W-1:0] w;
    logic         d;
    logic         x;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, mode_med = 1'b0;
  logic [W-1:0] word_a = '0, word_b = '0, word_c = '0;
  logic out_valid, out_disagree, out_alldiff;
  logic [W-1:0] out_word;

  int n_cmp = 0, n_bad = 0;
  exp_t q[$];
  logic [W-1:0] last_w;
  logic last_d, last_x;

  always #4 clk = ~clk;

  word_vote3 #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode_med(mode_med),
    .word_a(word_a), .word_b(word_b), .word_c(word_c),
    .out_valid(out_valid), .out_word(out_word),
    .out_disagree(out_disagree), .out_alldiff(out_alldiff)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] med3(input logic [W-1:0] a, b, c);
    if ((a >= b && a <= c) || (a <= b && a >= c)) return a;
    if ((b >= a && b <= c) || (b <= a && b >= c)) return b;
    return c;
  endfunction

  task automatic drive(input logic m, input logic [W-1:0] a, b, c, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; mode_med = m; word_a = a; word_b = b; word_c = c;
    e.w   = m ? med3(a, b, c) : ((a == b) ? a : c);
    e.d   = (a != b);
    e.x   = (a != b) && (b != c) && (a != c);
    e.tag = tag;
    last_w = e.w; last_d = e.d; last_x = e.x;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; mode_med = ~mode_med;
      word_a = word_a + 8'd17; word_b = word_b + 8'd29; word_c = word_c + 8'd3;
    end
  endtask

  // monitor / scoreboard (R7 pairing)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (out_valid) begin
          if (q.size() == 0) chk("R7 unexpected out_valid", 1, 0);
          else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " word"}, out_word, e.w);
            chk("R4 disagree", W'(out_disagree), W'(e.d));
            chk("R6 alldiff", W'(out_alldiff), W'(e.x));
          end
        end else if (q.size() > 1) begin
          chk("R7 missing out_valid", 0, 1);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", W'(out_valid), 0);
    chk("R1 word in reset", out_word, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", W'(out_valid), 0);
    chk("R1 word after reset", out_word, 0);
    chk("R1 flags after reset", W'({out_disagree, out_alldiff}), 0);

    drive(0, 8'd42, 8'd42, 8'd7, "R2 match");
    drive(0, 8'd42, 8'd43, 8'd7, "R3 mismatch");
    drive(0, 8'd1, 8'd2, 8'd1, "R3 c equals a");
    drive(0, 8'd9, 8'd9, 8'd9, "R2 all equal");
    drive(0, 8'd255, 8'd0, 8'd128, "R3 all differ");
    drive(1, 8'd10, 8'd20, 8'd30, "R5 abc");
    drive(1, 8'd30, 8'd10, 8'd20, "R5 cab");
    drive(1, 8'd20, 8'd30, 8'd10, "R5 bca");
    drive(1, 8'd30, 8'd20, 8'd10, "R5 cba");
    drive(1, 8'd10, 8'd30, 8'd20, "R5 acb");
    drive(1, 8'd20, 8'd10, 8'd30, "R5 bac");
    drive(1, 8'd5, 8'd5, 8'd9, "R5 tie low");
    drive(1, 8'd9, 8'd5, 8'd9, "R5 tie high");
    drive(1, 8'd200, 8'd3, 8'd255, "R5 unsigned");
    drive(1, 8'd7, 8'd7, 8'd7, "R5 all tie");
    // R9: arbitrary patterns, scoreboard confirms a whole input word
    for (int i = 0; i < 40; i++)
      drive(i[0], W'(i * 37), W'(i * 11 + (i % 3 == 0 ? 0 : 1)), W'(i * 73), "R9 sweep");

    drive(0, 8'd100, 8'd101, 8'd77, "R8 pre-idle");
    idle(1);
    idle(4);
    chk("R8 hold word", out_word, last_w);
    chk("R8 hold disagree", W'(out_disagree), W'(last_d));
    chk("R8 hold alldiff", W'(out_alldiff), W'(last_x));
    chk("R7 idle valid", W'(out_valid), 0);

    drive(1, 8'd4, 8'd8, 8'd6, "R7 after idle");
    idle(3);
    chk("R7 queue drained", W'(q.size()), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule